// File: doc/BRIEF.md
# Narrow-Write Coalescing Register Bridge

The bridge sits between a host bus that issues byte, halfword and word accesses and a peripheral register file that only takes full 32-bit word writes. Ordinary narrow writes become a read-modify-write of the aligned word. Narrow reads fetch the aligned word and return the addressed lane.

The halfwords that set up a data transfer are held back. These are the block size, the block count and the transfer mode. The first two share one word, and the transfer mode shares its word with the command halfword. The held values reach the peripheral only when the command halfword is written. At that point a nonzero block word is written out once, and then the combined command/transfer-mode word follows. The peripheral samples writes across a clock crossing. To keep two writes from landing too close together, every word write is followed by a stall measured in microsecond ticks whenever the peripheral clock is slow.

The host sees a single valid/ready request channel. Read data comes back on a one-cycle valid pulse. The peripheral side is a simple request port whose read data arrives one cycle after the read request.

Top module: `nwb_bridge`

## Requirements
- R1: A read returns the aligned peripheral word shifted right by 8 × address[1:0] and masked to 8 bits (size code 0), 16 bits (size code 1) or 32 bits (size code 2). It is delivered on `h_rdata` with a one-cycle `h_rvalid`.
- R2: A halfword write to byte address BLK_ADDR (block size, low lane) or BLK_ADDR+2 (block count, high lane) is merged into the block shadow word and causes no peripheral access. A later word read of BLK_ADDR still returns the peripheral's own value.
- R3: A halfword write to CMD_ADDR (transfer mode, low lane) is merged into the command shadow word and causes no peripheral access.
- R4: A halfword write to CMD_ADDR+2 (command, high lane) is handled in two steps. First, if the block shadow is nonzero, it is written to BLK_ADDR and the shadow is cleared. Then the command halfword is merged into the command shadow, and the whole command shadow word is written to CMD_ADDR.
- R5: A command write while the block shadow is zero produces exactly one peripheral write, the one to CMD_ADDR.
- R6: Every byte write, and every halfword write outside the shadowed addresses, reads the aligned word. The new data is inserted under a 0xFF or 0xFFFF mask at the lane offset, and the result is written back.
- R7: A word write goes to the peripheral unchanged at its aligned address and does not touch either shadow.
- R8: Each peripheral word write is followed by a stall counted in `cfg_us_tick` pulses. If `cfg_pclk_khz` is zero, the stall is 10 ticks. If it is from 1 to 400, the stall is ceil(4000 / kHz) ticks. Above 400 there is no stall.
- R9: `h_ready` is low whenever the bridge is reading, writing, flushing or stalling. No host access is accepted then.
- R10: After reset both shadows are zero, `h_ready` is high and no peripheral request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pclk_khz | input | KHZW | Peripheral clock frequency in kHz; 0 means unknown |
| cfg_us_tick | input | 1 | One-cycle pulse every microsecond |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | Bridge can accept an access this cycle |
| h_we | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | 0 byte, 1 halfword, 2 word |
| h_addr | input | AW | Host byte address (halfwords even, words aligned) |
| h_wdata | input | 32 | Write data, right-aligned |
| h_rvalid | output | 1 | Read data valid pulse |
| h_rdata | output | 32 | Read data, right-aligned |
| p_req | output | 1 | Peripheral access this cycle |
| p_we | output | 1 | Peripheral access is a write |
| p_addr | output | AW | Peripheral word address |
| p_wdata | output | 32 | Peripheral write word |
| p_rdata | input | 32 | Peripheral read word, one cycle after a read request |

## Verification
The bench reads a word of distinct bytes through every byte and halfword lane, so a wrong lane shift or mask gives a different value. Narrow writes into plain registers are checked against the expected merged word, which shows that the neighbouring lanes are kept. Several shadow sequences are run: a command with an empty block shadow, a full set-up followed by a command, and a second command issued straight after. Together they separate a missing flush, a flush that is not cleared afterwards, and a transfer-mode value that is lost. Pacing is measured in ticks between consecutive writes at 300 kHz, 400 kHz, 401 kHz, zero and a fast clock, which covers the rounding, the limit and the zero-clock fallback.

// File: rtl/nwb_pkg.sv
// Shared types and constants for the narrow-write bridge.
// Assumes a 32-bit peripheral data path.
package nwb_pkg;

    localparam int unsigned WORD_W         = 32;
    localparam int unsigned PACE_PERIODS   = 4;    // slow-clock periods between writes
    localparam int unsigned SLOW_LIMIT_KHZ = 400;  // at or below this, pacing applies
    localparam int unsigned ZERO_CLK_US    = 10;   // stall when clock is unknown

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RDDONE,
        ST_FLUSH,
        ST_WR,
        ST_PACE
    } br_state_e;

    // Lane mask for an access size, right-aligned.
    function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    // Pull one lane out of a word.
    function automatic logic [WORD_W-1:0] lane_extract(input logic [WORD_W-1:0] w,
                                                      input logic [1:0] lane,
                                                      input logic [1:0] sz);
        logic [4:0] sh;
        sh = {lane, 3'b000};
        lane_extract = (w >> sh) & size_mask(sz);
    endfunction

endpackage

// File: rtl/nwb_lane.sv
// Lane merge: inserts right-aligned data into a word at the lane offset
// given by the low address bits, keeping all other lanes.
// Assumes halfword accesses are even and word accesses aligned.
module nwb_lane
    import nwb_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [1:0]        lane_i,
    input  logic [1:0]        size_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] merged_o
);

    logic [4:0]        shift;
    logic [WORD_W-1:0] mask;

    // Build shifted mask and merge new data under it.
    always_comb begin
        shift    = {lane_i, 3'b000};
        mask     = size_mask(size_i);
        merged_o = (word_i & ~(mask << shift)) | ((data_i & mask) << shift);
    end

endmodule

// File: rtl/nwb_shadow.sv
// Holding registers for the deferred block word and command word.
// Assumes clear and load of the block word never coincide.
module nwb_shadow
    import nwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_we_i,
    input  logic [WORD_W-1:0] blk_d_i,
    input  logic              blk_clr_i,
    input  logic              cmd_we_i,
    input  logic [WORD_W-1:0] cmd_d_i,
    output logic [WORD_W-1:0] blk_q_o,
    output logic [WORD_W-1:0] cmd_q_o
);

    // Block shadow: load on merge, clear after flush.
    always_ff @(posedge clk) begin
        if (!rst_n)         blk_q_o <= '0;
        else if (blk_clr_i) blk_q_o <= '0;
        else if (blk_we_i)  blk_q_o <= blk_d_i;
    end

    // Command shadow: load on transfer-mode or command merge.
    always_ff @(posedge clk) begin
        if (!rst_n)        cmd_q_o <= '0;
        else if (cmd_we_i) cmd_q_o <= cmd_d_i;
    end

endmodule

// File: rtl/nwb_pacer.sv
// Post-write stall timer. Counts microsecond ticks, adding the clock
// frequency in kHz per tick, until 1000*PACE_PERIODS is reached. This
// gives ceil(4000/kHz) ticks without a divider. A zero frequency uses a
// step that yields ZERO_CLK_US ticks.
// Assumes cfg frequency is stable while a stall is running.
module nwb_pacer
    import nwb_pkg::*;
#(
    parameter int unsigned KHZW = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [KHZW-1:0] khz_i,
    input  logic            tick_i,
    output logic            need_o,
    output logic            busy_o
);

    localparam int unsigned NUM   = PACE_PERIODS * 1000;
    localparam int unsigned ZSTEP = NUM / ZERO_CLK_US;
    localparam int unsigned ACCW  = $clog2(NUM + SLOW_LIMIT_KHZ + 1) + 1;

    logic [ACCW-1:0] acc_q;
    logic [ACCW-1:0] step;
    logic [ACCW-1:0] sum;
    logic            active_q;

    // Decide whether pacing applies and the per-tick step.
    always_comb begin
        need_o = (khz_i <= KHZW'(SLOW_LIMIT_KHZ));
        step   = (khz_i == '0) ? ACCW'(ZSTEP) : ACCW'(khz_i);
        sum    = acc_q + step;
        busy_o = active_q;
    end

    // Accumulate ticks while a stall is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            acc_q    <= '0;
        end else if (start_i) begin
            active_q <= need_o;
            acc_q    <= '0;
        end else if (active_q && tick_i) begin
            acc_q <= sum;
            if (sum >= ACCW'(NUM)) active_q <= 1'b0;
        end
    end

    assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !tick_i && !start_i) |=> active_q);

    assert_fast_clock_no_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !need_o) |=> !busy_o);

endmodule

// File: rtl/nwb_bridge.sv
// Narrow-write coalescing bridge top. Accepts one host access at a time
// and sequences it into peripheral word reads and writes. Block and
// transfer-mode halfwords are held until the command halfword arrives.
// Every word write is followed by a paced stall.
// Assumes the peripheral returns read data one cycle after p_req.
module nwb_bridge
    import nwb_pkg::*;
#(
    parameter int unsigned AW       = 8,
    parameter int unsigned KHZW     = 20,
    parameter logic [7:0]  BLK_ADDR = 8'h04,
    parameter logic [7:0]  CMD_ADDR = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KHZW-1:0]   cfg_pclk_khz,
    input  logic              cfg_us_tick,
    input  logic              h_valid,
    output logic              h_ready,
    input  logic              h_we,
    input  logic [1:0]        h_size,
    input  logic [AW-1:0]     h_addr,
    input  logic [WORD_W-1:0] h_wdata,
    output logic              h_rvalid,
    output logic [WORD_W-1:0] h_rdata,
    output logic              p_req,
    output logic              p_we,
    output logic [AW-1:0]     p_addr,
    output logic [WORD_W-1:0] p_wdata,
    input  logic [WORD_W-1:0] p_rdata
);

    localparam logic [AW-1:0] BLK_W = AW'(BLK_ADDR);
    localparam logic [AW-1:0] CMD_W = AW'(CMD_ADDR);

    br_state_e         state_q;
    logic [AW-1:0]     q_addr;
    logic [1:0]        q_size;
    logic              q_we;
    logic [WORD_W-1:0] q_wdata;
    logic [WORD_W-1:0] wbuf_q;
    logic [AW-1:0]     wadr_q;
    logic              after_flush_q;
    logic [WORD_W-1:0] rdata_q;
    logic              rvalid_q;

    logic              accept;
    logic [AW-1:0]     h_word;
    logic              is_half_wr;
    logic              hit_blk, hit_tm, hit_cmd;
    logic [WORD_W-1:0] blk_q, cmd_q;
    logic [WORD_W-1:0] blk_merged, cmd_merged, per_merged;
    logic              blk_clr;
    logic              pace_need, pace_busy;
    logic              wr_start;

    // Host-side decode of the incoming access.
    always_comb begin
        accept     = h_valid && h_ready;
        h_word     = {h_addr[AW-1:2], 2'b00};
        is_half_wr = h_we && (h_size == SZ_HALF);
        hit_blk    = is_half_wr && (h_word == BLK_W);
        hit_tm     = is_half_wr && (h_word == CMD_W) && !h_addr[1];
        hit_cmd    = is_half_wr && (h_word == CMD_W) &&  h_addr[1];
    end

    nwb_lane u_blk_lane (
        .word_i   (blk_q),
        .lane_i   (h_addr[1:0]),
        .size_i   (h_size),
        .data_i   (h_wdata),
        .merged_o (blk_merged)
    );

    nwb_lane u_cmd_lane (
        .word_i   (cmd_q),
        .lane_i   (h_addr[1:0]),
        .size_i   (h_size),
        .data_i   (h_wdata),
        .merged_o (cmd_merged)
    );

    nwb_lane u_per_lane (
        .word_i   (p_rdata),
        .lane_i   (q_addr[1:0]),
        .size_i   (q_size),
        .data_i   (q_wdata),
        .merged_o (per_merged)
    );

    nwb_shadow u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_we_i  (accept && hit_blk),
        .blk_d_i   (blk_merged),
        .blk_clr_i (blk_clr),
        .cmd_we_i  (accept && (hit_tm || hit_cmd)),
        .cmd_d_i   (cmd_merged),
        .blk_q_o   (blk_q),
        .cmd_q_o   (cmd_q)
    );

    nwb_pacer #(.KHZW(KHZW)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wr_start),
        .khz_i   (cfg_pclk_khz),
        .tick_i  (cfg_us_tick),
        .need_o  (pace_need),
        .busy_o  (pace_busy)
    );

    // Peripheral request and host ready driven from the sequencer state.
    always_comb begin
        p_req   = 1'b0;
        p_we    = 1'b0;
        p_addr  = '0;
        p_wdata = '0;
        blk_clr = 1'b0;
        case (state_q)
            ST_RD: begin
                p_req  = 1'b1;
                p_addr = {q_addr[AW-1:2], 2'b00};
            end
            ST_FLUSH: begin
                p_req   = 1'b1;
                p_we    = 1'b1;
                p_addr  = BLK_W;
                p_wdata = blk_q;
                blk_clr = 1'b1;
            end
            ST_WR: begin
                p_req   = 1'b1;
                p_we    = 1'b1;
                p_addr  = wadr_q;
                p_wdata = wbuf_q;
            end
            default: ;
        endcase
        wr_start = p_req && p_we;
        h_ready  = (state_q == ST_IDLE);
        h_rvalid = rvalid_q;
        h_rdata  = rdata_q;
    end

    // Access sequencer: latch, read, merge, flush, write, stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            q_addr        <= '0;
            q_size        <= SZ_BYTE;
            q_we          <= 1'b0;
            q_wdata       <= '0;
            wbuf_q        <= '0;
            wadr_q        <= '0;
            after_flush_q <= 1'b0;
            rdata_q       <= '0;
            rvalid_q      <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        q_addr  <= h_addr;
                        q_size  <= h_size;
                        q_we    <= h_we;
                        q_wdata <= h_wdata;
                        if (h_we && (h_size == SZ_WORD)) begin
                            wbuf_q  <= h_wdata;
                            wadr_q  <= h_word;
                            state_q <= ST_WR;
                        end else if (hit_cmd) begin
                            wbuf_q  <= cmd_merged;
                            wadr_q  <= CMD_W;
                            state_q <= (blk_q != '0) ? ST_FLUSH : ST_WR;
                        end else if (!(hit_blk || hit_tm)) begin
                            state_q <= ST_RD;
                        end
                    end
                end
                ST_RD: state_q <= ST_RDDONE;
                ST_RDDONE: begin
                    if (q_we) begin
                        wbuf_q  <= per_merged;
                        wadr_q  <= {q_addr[AW-1:2], 2'b00};
                        state_q <= ST_WR;
                    end else begin
                        rdata_q  <= lane_extract(p_rdata, q_addr[1:0], q_size);
                        rvalid_q <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                ST_FLUSH: begin
                    after_flush_q <= 1'b1;
                    state_q       <= pace_need ? ST_PACE : ST_WR;
                end
                ST_WR: begin
                    after_flush_q <= 1'b0;
                    state_q       <= pace_need ? ST_PACE : ST_IDLE;
                end
                ST_PACE: begin
                    if (!pace_busy) state_q <= after_flush_q ? ST_WR : ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_blk_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_blk) |=> !p_req);

    assert_tm_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_tm) |=> !p_req);

    assert_flush_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && p_we && state_q == ST_FLUSH) |=> (blk_q == '0));

    assert_empty_no_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_cmd && blk_q == '0) |=> (p_req && p_we && p_addr == CMD_W));

    assert_rmw_write_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDDONE && q_we) |=> (p_req && p_we));

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req || pace_busy) |-> !h_ready);

    assert_reset_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (h_ready && !p_req && blk_q == '0 && cmd_q == '0));

endmodule

// File: tb/nwb_bridge_tb_top.sv
module nwb_bridge_tb_top;

    localparam int AW   = 8;
    localparam int KHZW = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [KHZW-1:0] cfg_pclk_khz = 20'd25000;
    logic            cfg_us_tick = 1'b0;
    logic            h_valid = 1'b0;
    logic            h_ready;
    logic            h_we = 1'b0;
    logic [1:0]      h_size = 2'd0;
    logic [AW-1:0]   h_addr = '0;
    logic [31:0]     h_wdata = '0;
    logic            h_rvalid;
    logic [31:0]     h_rdata;
    logic            p_req, p_we;
    logic [AW-1:0]   p_addr;
    logic [31:0]     p_wdata;
    logic [31:0]     p_rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    nwb_bridge #(.AW(AW), .KHZW(KHZW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_pclk_khz(cfg_pclk_khz), .cfg_us_tick(cfg_us_tick),
        .h_valid(h_valid), .h_ready(h_ready), .h_we(h_we), .h_size(h_size),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
        .p_req(p_req), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata)
    );

    // Peripheral model: 16 words, read data one cycle after request.
    logic [31:0] pmem [16];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) pmem[i] <= '0;
            p_rdata <= '0;
        end else begin
            if (p_req && !p_we) p_rdata <= pmem[p_addr[5:2]];
            if (p_req && p_we)  pmem[p_addr[5:2]] <= p_wdata;
        end
    end

    // Microsecond tick every 5 cycles.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            cfg_us_tick = (cyc % 5 == 0);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected peripheral writes, in order.
    logic [AW-1:0] exp_a[$];
    logic [31:0]   exp_d[$];
    string         exp_t[$];

    task automatic expect_wr(input logic [AW-1:0] a, input logic [31:0] d, input string t);
        exp_a.push_back(a); exp_d.push_back(d); exp_t.push_back(t);
    endtask

    function automatic int exp_ticks(input int khz);
        if (khz == 0) return 10;
        if (khz <= 400) return (4000 + khz - 1) / khz;
        return 0;
    endfunction

    // Per-clock monitor: every write matches the queue, gaps are paced.
    bit counting = 0;
    int tcount   = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (counting) begin
                    if ((p_req && p_we) || h_ready) begin
                        check("R8 stall ticks", tcount, exp_ticks(int'(cfg_pclk_khz)));
                        counting = 0;
                    end else if (cfg_us_tick) tcount++;
                end
                if (p_req && p_we) begin
                    if (exp_a.size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R2 unexpected write: actual %h@%h expected none", p_wdata, p_addr);
                    end else begin
                        string t;
                        t = exp_t.pop_front();
                        check({t, " write addr"}, 32'(p_addr), 32'(exp_a.pop_front()));
                        check({t, " write data"}, p_wdata, exp_d.pop_front());
                    end
                    counting = 1;
                    tcount = 0;
                end
            end
        end
    end

    task automatic host_op(input logic we, input logic [1:0] sz, input logic [AW-1:0] a,
                           input logic [31:0] d);
        @(negedge clk);
        h_valid = 1'b1; h_we = we; h_size = sz; h_addr = a; h_wdata = d;
        while (!h_ready) @(negedge clk);
        @(negedge clk);
        h_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!h_ready) @(negedge clk);
    endtask

    task automatic host_read(input logic [1:0] sz, input logic [AW-1:0] a,
                             input logic [31:0] exp, input string tag);
        int n;
        host_op(1'b0, sz, a, 32'h0);
        n = 0;
        while (!h_rvalid && n < 10) begin @(negedge clk); n++; end
        check({tag, " rvalid"}, 32'(h_rvalid), 32'd1);
        check(tag, h_rdata, exp);
        wait_idle();
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 ready after reset", 32'(h_ready), 32'd1);
        check("R10 no request after reset", 32'(p_req), 32'd0);

        // R10 / R5: empty block shadow -> one command write with zero low lane.
        expect_wr(8'h0C, 32'h0011_0000, "R5");
        host_op(1'b1, 2'd1, 8'h0E, 32'h0011);
        wait_idle();

        // R7: word writes go straight through.
        expect_wr(8'h10, 32'h1122_3344, "R7");
        host_op(1'b1, 2'd2, 8'h10, 32'h1122_3344);
        wait_idle();
        expect_wr(8'h14, 32'hA5A5_5A5A, "R7");
        host_op(1'b1, 2'd2, 8'h14, 32'hA5A5_5A5A);
        wait_idle();

        // R1: lane extraction on reads.
        host_read(2'd0, 8'h10, 32'h44, "R1 byte0");
        host_read(2'd0, 8'h11, 32'h33, "R1 byte1");
        host_read(2'd0, 8'h12, 32'h22, "R1 byte2");
        host_read(2'd0, 8'h13, 32'h11, "R1 byte3");
        host_read(2'd1, 8'h10, 32'h3344, "R1 half0");
        host_read(2'd1, 8'h12, 32'h1122, "R1 half1");
        host_read(2'd2, 8'h14, 32'hA5A5_5A5A, "R1 word");

        // R6: read-modify-write of plain registers.
        expect_wr(8'h10, 32'h1122_EE44, "R6");
        host_op(1'b1, 2'd0, 8'h11, 32'h0000_00EE);
        wait_idle();
        expect_wr(8'h14, 32'hBEEF_5A5A, "R6");
        host_op(1'b1, 2'd1, 8'h16, 32'h0000_BEEF);
        wait_idle();
        host_read(2'd2, 8'h10, 32'h1122_EE44, "R6 readback");

        // R2 / R3: shadowed halfwords produce no access.
        host_op(1'b1, 2'd1, 8'h04, 32'h0200);
        check("R2 no access on block size", 32'(p_req), 32'd0);
        host_op(1'b1, 2'd1, 8'h06, 32'h0003);
        check("R2 no access on block count", 32'(p_req), 32'd0);
        host_read(2'd2, 8'h04, 32'h0, "R2 peripheral block word untouched");
        host_op(1'b1, 2'd1, 8'h0C, 32'h0012);
        check("R3 no access on transfer mode", 32'(p_req), 32'd0);

        // R4: command flushes block shadow then writes command word.
        expect_wr(8'h04, 32'h0003_0200, "R4 flush");
        expect_wr(8'h0C, 32'h0033_0012, "R4 command");
        host_op(1'b1, 2'd1, 8'h0E, 32'h0033);
        wait_idle();
        expect_wr(8'h0C, 32'h0044_0012, "R4 shadow cleared");
        host_op(1'b1, 2'd1, 8'h0E, 32'h0044);
        wait_idle();

        // R8 / R9: pacing at 300 kHz, including a paced flush.
        cfg_pclk_khz = 20'd300;
        expect_wr(8'h18, 32'h0000_0001, "R8 word");
        host_op(1'b1, 2'd2, 8'h18, 32'h1);
        @(negedge clk);
        check("R9 not ready while stalling", 32'(h_ready), 32'd0);
        wait_idle();
        host_op(1'b1, 2'd1, 8'h04, 32'h0040);
        expect_wr(8'h04, 32'h0000_0040, "R8 paced flush");
        expect_wr(8'h0C, 32'h0055_0012, "R8 paced command");
        host_op(1'b1, 2'd1, 8'h0E, 32'h0055);
        wait_idle();

        cfg_pclk_khz = 20'd0;
        expect_wr(8'h18, 32'h0000_0002, "R8 zero clock");
        host_op(1'b1, 2'd2, 8'h18, 32'h2);
        wait_idle();

        cfg_pclk_khz = 20'd400;
        expect_wr(8'h18, 32'h0000_0003, "R8 at limit");
        host_op(1'b1, 2'd2, 8'h18, 32'h3);
        wait_idle();

        cfg_pclk_khz = 20'd401;
        expect_wr(8'h18, 32'h0000_0004, "R8 above limit");
        host_op(1'b1, 2'd2, 8'h18, 32'h4);
        wait_idle();
        repeat (4) @(negedge clk);

        check("R4 all expected writes seen", 32'(exp_a.size()), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule